// File: doc/BRIEF.md
# Resize coefficient calculator

This unit works out the scaling setup for one image dimension. A start pulse hands it an input length, an output length, a direction select and an optional user ratio. It first checks that the request is in range. It then chooses a power-of-two pre-decimation of zero, one or two halvings. Finally it computes a fixed-point step with 13 fraction bits using a restoring divider that produces one quotient bit per clock. The outcome is a 32-bit word with the step and the halving code placed in the vertical or horizontal half. The word comes with a one-cycle done pulse and an error flag.

A nonzero user ratio that fits the 14-bit step field skips the whole calculation and is placed in the step field as given. Two instances, one per axis, can have their outputs ORed together to form a complete scaler setup word. The pixel scaler that consumes the word is not part of this block.

Top module: `rsz_coef_calc`

## Requirements
- R1: When ratio_i is nonzero and below 16384, the result carries ratio_i in the step field with a halving code of 0 and no error, and no range check is applied.
- R2: With the calculation selected, an input length above 4096 or an output length above 1024 gives err_o = 1 and reg_o = 0.
- R3: With the calculation selected, a request where 8 × output length < input length gives err_o = 1 and reg_o = 0.
- R4: With the calculation selected, an output length below 2 or an input length of 0 gives err_o = 1 and reg_o = 0.
- R5: The working length starts at the input length. It is halved (shifted right by one) and the halving code is incremented while it exceeds 1024 or is at least twice the output length, and at most two times, so the code ends at 0, 1 or 2.
- R6: The step equals floor(8192 × (working length − 1) / (output length − 1)).
- R7: A step of 16384 or more is replaced by 16383 (0x3FFF).
- R8: With vert_i = 1 the halving code sits in reg_o[31:30] and the step in reg_o[29:16], with reg_o[15:0] = 0. With vert_i = 0 the code sits in reg_o[15:14] and the step in reg_o[13:0], with reg_o[31:16] = 0.
- R9: done_o is high for exactly one cycle per accepted request. reg_o and err_o change only at that cycle and hold until the next completion.
- R10: busy_o is high from the cycle after an accepted start until done_o. A start while busy_o is high is ignored and does not alter the result in progress.
- R11: After reset, busy_o, done_o, err_o and reg_o are all 0.
- R12: A ratio_i of 0 or of 16384 or more selects the calculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, sampled when idle |
| vert_i | input | 1 | 1 places the result in the upper half, 0 in the lower half |
| in_len_i | input | LEN_W (16) | Input length |
| out_len_i | input | LEN_W (16) | Output length |
| ratio_i | input | RATIO_W (16) | User ratio; nonzero and below 16384 bypasses the calculation |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request rejected |
| reg_o | output | 32 | Packed halving code and step |

## Verification
The bench builds the unit with its default parameters: 16-bit length ports, input and output limits of 4096 and 1024, at most two halvings, 13 fraction bits, and a divider with a 26-bit numerator and an 11-bit divisor. With 16-bit length ports, lengths just past both limits can be driven, so the exact edges 4096/4097 and 1024/1025 are reachable. The 26-cycle divider leaves a wide window in which a second start can be driven while busy. The small halving limit means cases such as 16 to 2 exhaust the halving loop and push the step into saturation.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

    localparam int RSZ_COEF_W = 14;
    localparam int RSZ_DS_W   = 2;
    localparam int RSZ_HALF_W = RSZ_COEF_W + RSZ_DS_W;
    localparam int RSZ_REG_W  = 2 * RSZ_HALF_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DIV  = 2'd2
    } rsz_state_e;

    typedef struct packed {
        logic [RSZ_DS_W-1:0]   ds;
        logic [RSZ_COEF_W-1:0] coef;
    } rsz_half_t;

    // Place one half into the upper or lower part of the packed word.
    function automatic logic [RSZ_REG_W-1:0] rsz_place(input logic vert,
                                                       input rsz_half_t h);
        logic [RSZ_REG_W-1:0] w;
        if (vert) w = {h, {RSZ_HALF_W{1'b0}}};
        else      w = {{RSZ_HALF_W{1'b0}}, h};
        return w;
    endfunction

endpackage

// File: rtl/rsz_downsize.sv
module rsz_downsize #(
    parameter int WS_W   = 13,
    parameter int DEN_W  = 11,
    parameter int LIMIT  = 1024,
    parameter int DS_MAX = 2,
    parameter int DS_W   = 2
) (
    input  logic [WS_W-1:0]  len_in,
    input  logic [DEN_W-1:0] len_out,
    output logic [WS_W-1:0]  ws,
    output logic [DS_W-1:0]  ds
);
    localparam int CW = WS_W + 1;
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    logic [CW-1:0] twice_out;
    assign twice_out = CW'({len_out, 1'b0});

    // Unrolled halving chain; each stage only acts while the previous one did.
    logic [WS_W-1:0] stage_ws [DS_MAX+1];
    logic [DS_W-1:0] stage_ds [DS_MAX+1];
    logic            stage_go [DS_MAX+1];

    assign stage_ws[0] = len_in;
    assign stage_ds[0] = '0;
    assign stage_go[0] = 1'b1;

    for (genvar s = 0; s < DS_MAX; s++) begin : g_stage
        logic want;
        assign want = stage_go[s] &&
                      ((CW'(stage_ws[s]) > LIMIT_C) || (CW'(stage_ws[s]) >= twice_out));
        assign stage_ws[s+1] = want ? (stage_ws[s] >> 1) : stage_ws[s];
        assign stage_ds[s+1] = want ? (stage_ds[s] + DS_W'(1)) : stage_ds[s];
        assign stage_go[s+1] = want;
    end

    assign ws = stage_ws[DS_MAX];
    assign ds = stage_ds[DS_MAX];

endmodule

// File: rtl/rsz_divider.sv
module rsz_divider #(
    parameter int NUM_W = 26,
    parameter int DEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo,
    output logic [DEN_W:0]   rem
);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam int PW    = NUM_W + DEN_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;

    logic [DEN_W:0] shifted;
    logic [DEN_W:0] trial;
    logic           fits;

    always_comb begin
        shifted = {rem[DEN_W-1:0], quo[NUM_W-1]};
        trial   = shifted - {1'b0, den_q};
        fits    = shifted >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
            quo   <= '0;
            rem   <= '0;
            num_q <= '0;
            den_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(NUM_W);
            run_q <= 1'b1;
            done  <= 1'b0;
            quo   <= num;
            rem   <= '0;
            num_q <= num;
            den_q <= den;
        end else if (run_q) begin
            rem   <= fits ? trial : shifted;
            quo   <= {quo[NUM_W-2:0], fits};
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
                run_q <= 1'b0;
                done  <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R6: the finished quotient and remainder reconstruct the numerator
    a_r6_div_exact: assert property (@(posedge clk) disable iff (rst)
        done |-> ((PW'(quo) * PW'(den_q) + PW'(rem)) == PW'(num_q)) && (rem < {1'b0, den_q}));

endmodule

// File: rtl/rsz_packer.sv
module rsz_packer
    import rsz_pkg::*;
(
    input  logic                  vert,
    input  logic [RSZ_DS_W-1:0]   ds,
    input  logic [RSZ_COEF_W-1:0] coef,
    output logic [RSZ_REG_W-1:0]  word
);
    rsz_half_t h;
    always_comb begin
        h.ds   = ds;
        h.coef = coef;
        word   = rsz_place(vert, h);
    end
endmodule

// File: rtl/rsz_coef_calc.sv
module rsz_coef_calc
    import rsz_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int RATIO_W   = 16,
    parameter int MAX_IN    = 4096,
    parameter int MAX_OUT   = 1024,
    parameter int DS_MAX    = 2,
    parameter int FRAC_BITS = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 vert_i,
    input  logic [LEN_W-1:0]     in_len_i,
    input  logic [LEN_W-1:0]     out_len_i,
    input  logic [RATIO_W-1:0]   ratio_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic [RSZ_REG_W-1:0] reg_o
);
    localparam int WS_W   = $clog2(MAX_IN + 1);
    localparam int DEN_W  = $clog2(MAX_OUT + 1);
    localparam int NUM_W  = WS_W + FRAC_BITS;
    localparam int CMP_W  = LEN_W + 3;
    localparam logic [LEN_W-1:0]   MAX_IN_L  = LEN_W'(MAX_IN);
    localparam logic [LEN_W-1:0]   MAX_OUT_L = LEN_W'(MAX_OUT);
    localparam logic [RATIO_W-1:0] RATIO_LIM = RATIO_W'(1 << RSZ_COEF_W);
    localparam logic [NUM_W-1:0]   SAT_LIM   = NUM_W'(1 << RSZ_COEF_W);

    rsz_state_e           state_q;
    logic [LEN_W-1:0]     in_q;
    logic [LEN_W-1:0]     out_q;
    logic [RATIO_W-1:0]   ratio_q;
    logic                 vert_q;
    logic [RSZ_DS_W-1:0]  ds_q;

    logic                 done_q;
    logic                 err_q;
    logic [RSZ_REG_W-1:0] reg_q;

    // Request classification on the latched operands
    logic bypass, len_big, too_far, too_small, reject;
    always_comb begin
        bypass    = (ratio_q != '0) && (ratio_q < RATIO_LIM);
        len_big   = (in_q > MAX_IN_L) || (out_q > MAX_OUT_L);
        too_far   = {out_q, 3'b000} < CMP_W'(in_q);
        too_small = (out_q < LEN_W'(2)) || (in_q == '0);
        reject    = len_big || too_far || too_small;
    end

    // Halving selection
    logic [WS_W-1:0]     ws;
    logic [RSZ_DS_W-1:0] ds_sel;

    rsz_downsize #(
        .WS_W   (WS_W),
        .DEN_W  (DEN_W),
        .LIMIT  (MAX_OUT),
        .DS_MAX (DS_MAX),
        .DS_W   (RSZ_DS_W)
    ) u_downsize (
        .len_in  (in_q[WS_W-1:0]),
        .len_out (out_q[DEN_W-1:0]),
        .ws      (ws),
        .ds      (ds_sel)
    );

    // Division operands
    logic             div_start;
    logic [NUM_W-1:0] div_num;
    logic [DEN_W-1:0] div_den;
    logic             div_done;
    logic [NUM_W-1:0] div_quo;
    logic [DEN_W:0]   div_rem;

    always_comb begin
        div_start = (state_q == ST_EVAL) && !bypass && !reject;
        div_num   = {ws - WS_W'(1), {FRAC_BITS{1'b0}}};
        div_den   = out_q[DEN_W-1:0] - DEN_W'(1);
    end

    rsz_divider #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo),
        .rem   (div_rem)
    );

    // Saturation and packing
    logic [RSZ_COEF_W-1:0] coef_sat;
    logic [RSZ_COEF_W-1:0] pk_coef;
    logic [RSZ_DS_W-1:0]   pk_ds;
    logic [RSZ_REG_W-1:0]  pk_word;

    always_comb begin
        coef_sat = (div_quo >= SAT_LIM) ? {RSZ_COEF_W{1'b1}} : div_quo[RSZ_COEF_W-1:0];
        if (state_q == ST_EVAL) begin
            pk_coef = ratio_q[RSZ_COEF_W-1:0];
            pk_ds   = '0;
        end else begin
            pk_coef = coef_sat;
            pk_ds   = ds_q;
        end
    end

    rsz_packer u_pack (
        .vert (vert_q),
        .ds   (pk_ds),
        .coef (pk_coef),
        .word (pk_word)
    );

    // Control
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            in_q    <= '0;
            out_q   <= '0;
            ratio_q <= '0;
            vert_q  <= 1'b0;
            ds_q    <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            reg_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        in_q    <= in_len_i;
                        out_q   <= out_len_i;
                        ratio_q <= ratio_i;
                        vert_q  <= vert_i;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (bypass) begin
                        reg_q   <= pk_word;
                        err_q   <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (reject) begin
                        reg_q   <= '0;
                        err_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        ds_q    <= ds_sel;
                        state_q <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        reg_q   <= pk_word;
                        err_q   <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;
    assign reg_o  = reg_q;

    // R9: completion is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9: a rejected request leaves an all-zero word
    a_r9_err_zero_word: assert property (@(posedge clk) disable iff (rst)
        (done_q && err_q) |-> (reg_q == '0));

    // R10: latched operands stay put while a request is in progress
    a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> ($stable(in_q) && $stable(out_q) && $stable(ratio_q) && $stable(vert_q)));

    // R8: the unused half of the word is clear after a vertical result
    a_r8_lower_clear: assert property (@(posedge clk) disable iff (rst)
        (done_q && vert_q) |-> (reg_q[RSZ_HALF_W-1:0] == '0));

    // R8: the unused half of the word is clear after a horizontal result
    a_r8_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (done_q && !vert_q) |-> (reg_q[RSZ_REG_W-1:RSZ_HALF_W] == '0));

endmodule

// File: tb/sim_rsz_coef_calc.sv
module sim_rsz_coef_calc;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        vert_i = 1'b0;
    logic [15:0] in_len_i = '0;
    logic [15:0] out_len_i = '0;
    logic [15:0] ratio_i = '0;
    logic        busy_o, done_o, err_o;
    logic [31:0] reg_o;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    rsz_coef_calc u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .vert_i(vert_i),
        .in_len_i(in_len_i), .out_len_i(out_len_i), .ratio_i(ratio_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .reg_o(reg_o)
    );

    // Expected {err, word} from the requirements
    function automatic logic [32:0] model(int inl, int outl, int ratio, bit vert);
        longint ws, c;
        int ds;
        logic [15:0] half;
        if (ratio != 0 && ratio < 16384) begin
            half = 16'(ratio);
            return {1'b0, vert ? {half, 16'h0} : {16'h0, half}};
        end
        if (inl > 4096 || outl > 1024 || outl < 2 || inl == 0 || outl * 8 < inl)
            return {1'b1, 32'h0};
        ws = inl;
        ds = 0;
        while ((ws > 1024 || ws >= 2 * outl) && ds < 2) begin
            ws = ws >> 1;
            ds++;
        end
        c = (64'd8192 * (ws - 1)) / (outl - 1);
        if (c >= 16384) c = 16383;
        half = {2'(ds), 14'(c)};
        return {1'b0, vert ? {half, 16'h0} : {16'h0, half}};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(string tag, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done_o) begin ok = 1'b1; break; end
        end
        if (!ok) check({tag, " timeout"}, 0, 1);
    endtask

    task automatic run_case(string tag, int inl, int outl, int ratio, bit vert);
        logic [32:0] e;
        bit ok;
        e = model(inl, outl, ratio, vert);
        @(negedge clk);
        start_i = 1'b1; vert_i = vert;
        in_len_i = 16'(inl); out_len_i = 16'(outl); ratio_i = 16'(ratio);
        @(negedge clk);
        start_i = 1'b0;
        check({tag, " busy"}, 64'(busy_o), 1);
        wait_done(tag, ok);
        if (ok) begin
            check({tag, " word"}, 64'(reg_o), 64'(e[31:0]));
            check({tag, " err"}, 64'(err_o), 64'(e[32]));
            @(negedge clk);
            check("R9 done pulse width", 64'(done_o), 0);
            check("R9 held word", 64'(reg_o), 64'(e[31:0]));
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [32:0] e;
        bit ok;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset busy", 64'(busy_o), 0);
        check("R11 reset done", 64'(done_o), 0);
        check("R11 reset err", 64'(err_o), 0);
        check("R11 reset word", 64'(reg_o), 0);

        run_case("R1 bypass vertical", 5000, 0, 1234, 1'b1);
        run_case("R1 bypass horizontal", 0, 1, 16383, 1'b0);
        run_case("R12 ratio at limit computes", 2, 4, 16384, 1'b0);
        run_case("R12 ratio zero computes", 300, 100, 0, 1'b1);
        run_case("R2 input too long", 4097, 1024, 0, 1'b0);
        run_case("R2 output too long", 1000, 1025, 0, 1'b1);
        run_case("R5 both limits exact", 4096, 1024, 0, 1'b1);
        run_case("R3 eight to one exact", 800, 100, 0, 1'b0);
        run_case("R3 beyond eight to one", 801, 100, 0, 1'b0);
        run_case("R4 output length one", 1, 1, 0, 1'b0);
        run_case("R4 input length zero", 0, 10, 0, 1'b1);
        run_case("R7 saturation", 16, 2, 0, 1'b1);
        run_case("R6 upscale", 2, 4, 0, 1'b0);
        run_case("R8 horizontal fields", 3000, 1000, 0, 1'b0);
        run_case("R8 vertical fields", 3000, 1000, 0, 1'b1);
        run_case("R9 error then clear", 1, 1, 0, 1'b1);
        run_case("R9 clear after error", 640, 480, 0, 1'b1);

        // R10: a start during a busy request is ignored
        e = model(16, 2, 0, 1'b1);
        @(negedge clk);
        start_i = 1'b1; vert_i = 1'b1; in_len_i = 16; out_len_i = 2; ratio_i = 0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1; vert_i = 1'b0; in_len_i = 100; out_len_i = 50; ratio_i = 77;
        @(negedge clk);
        start_i = 1'b0;
        wait_done("R10 busy start", ok);
        if (ok) begin
            check("R10 first request result", 64'(reg_o), 64'(e[31:0]));
            check("R10 first request err", 64'(err_o), 64'(e[32]));
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (done_o || busy_o) break;
            end
            check("R10 no second completion", 64'({done_o, busy_o}), 0);
            check("R10 word unchanged", 64'(reg_o), 64'(e[31:0]));
        end

        for (int n = 0; n < 400; n++) begin
            int inl, outl, ratio;
            bit vert;
            inl   = (($urandom % 8) == 0) ? int'($urandom_range(0, 4200)) : int'($urandom_range(1, 4096));
            outl  = (($urandom % 8) == 0) ? int'($urandom_range(0, 1100)) : int'($urandom_range(2, 1024));
            ratio = (($urandom % 4) == 0) ? int'($urandom_range(0, 20000)) : 0;
            vert  = 1'($urandom);
            run_case("R6 random", inl, outl, ratio, vert);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule